// File: doc/BRIEF.md
# Self-Hosted Debug Enable Arbiter

This block decides, cycle by cycle, whether debug exceptions may be taken at the exception level the core is currently running in. It holds a small set of debug control bits. Software loads them through a word-wide register-write port, with one select value for each source word. The block combines those bits with live core context: the current exception level, the security state, which of the higher levels exist, and the debug mask bit. From these it produces the level that debug exceptions route to and one flag saying whether they are allowed.

The routing decision sends debug exceptions to EL2 only on a non-secure core that implements EL2, and only when either of the two hypervisor trap controls is set. Otherwise they go to EL1. Two conditions veto debug outright: an OS lock, and a secure-side disable that applies when the core is secure and EL3 exists. When neither veto applies, levels below the routing target always take debug. Levels above the target never do. At the target level itself, debug needs kernel debug enable set and the mask clear. The monitor-debug and single-step enable bits are held here and presented to neighbouring logic.

Top module: `dbg_enable_arbiter`

## Requirements
- R1: After a synchronous active-high reset, every held control bit is 0. As a result, `mon_dbg_en` and `step_en` read 0, `target_el` reads 1 when no routing control is set, and `dbg_allowed` is 1 at level 0 and 0 at level 1.
- R2: A write with `wr_sel`=0 (scope word) loads monitor debug enable from data bit 15, kernel debug enable from bit 13 and single-step enable from bit 0. All other bits of the word are ignored. The new values are visible after the clock edge that samples `wr_en`=1.
- R3: A write with `wr_sel`=1 (EL3 configuration word) loads the secure debug disable from data bit 16.
- R4: A write with `wr_sel`=2 (lock word) loads the OS lock from data bit 0. Other bits of this word have no effect.
- R5: A write with `wr_sel`=3 (routing word) loads the trap-debug control from bit 0 and the trap-general control from bit 1. Routing treats the two as an OR.
- R6: While the OS lock is 1, `dbg_allowed` is 0 whatever the other inputs are.
- R7: While the secure debug disable is 1, `secure` is 1 and `has_el3` is 1, `dbg_allowed` is 0.
- R8: `target_el` is 2 when `has_el2` is 1, `secure` is 0 and either routing control is 1. Otherwise it is 1.
- R9: When `cur_el` equals `target_el` and no veto applies, `dbg_allowed` equals kernel debug enable AND NOT `dbg_mask`.
- R10: When no veto applies, `dbg_allowed` is 1 for `cur_el` below `target_el` and 0 for `cur_el` above it.
- R11: `target_el` and `dbg_allowed` follow the live context inputs combinationally, in the same cycle and with no register stage.
- R12: When `wr_en` is 0, the values on `wr_sel` and `wr_data` change no held bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Selects which control word is written (0 scope, 1 EL3 config, 2 lock, 3 routing) |
| wr_data | input | DATA_W | Write data word |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| secure | input | 1 | Core is in secure state |
| has_el2 | input | 1 | EL2 is implemented |
| has_el3 | input | 1 | EL3 is implemented |
| dbg_mask | input | 1 | Debug mask bit of the current process state |
| target_el | output | 2 | Level that debug exceptions route to (1 or 2) |
| dbg_allowed | output | 1 | Debug exceptions are permitted at the current level |
| mon_dbg_en | output | 1 | Held monitor debug enable |
| step_en | output | 1 | Held single-step enable |

## Verification
A held bit that loads from the wrong field, or a strobe that is not gated, shows up on the cycle after the faulty write. The directly held enables change at once, and the vetoes and routing appear as a changed `dbg_allowed` or `target_el` at the next context the bench presents. A stuck veto or a wrong comparison against the target level shows up as soon as the bench steps the current level across the target with the mask toggled. The bench therefore sweeps all four levels after each control change, so that every held bit is seen on some level within a few cycles of being written.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;

    typedef enum logic [1:0] {
        LVL_0 = 2'd0,
        LVL_1 = 2'd1,
        LVL_2 = 2'd2,
        LVL_3 = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        WSEL_SCOPE  = 2'd0,
        WSEL_EL3CFG = 2'd1,
        WSEL_LOCK   = 2'd2,
        WSEL_ROUTE  = 2'd3
    } wsel_e;

    localparam int SCOPE_MON_BIT   = 15;
    localparam int SCOPE_KERN_BIT  = 13;
    localparam int SCOPE_STEP_BIT  = 0;
    localparam int EL3CFG_SDIS_BIT = 16;
    localparam int LOCK_BIT        = 0;
    localparam int ROUTE_TDBG_BIT  = 0;
    localparam int ROUTE_TGEN_BIT  = 1;
    localparam int MIN_DATA_W      = EL3CFG_SDIS_BIT + 1;

    typedef struct packed {
        logic os_lock;
        logic sec_dis;
        logic kern_en;
        logic mon_en;
        logic step_en;
        logic trap_dbg;
        logic trap_gen;
    } dbg_ctrl_t;

    typedef struct packed {
        lvl_e lvl;
        logic secure;
        logic has_el2;
        logic has_el3;
        logic mask;
    } dbg_ctx_t;

    function automatic lvl_e route_level(input dbg_ctrl_t c, input dbg_ctx_t x);
        logic to_hyp;
        to_hyp = x.has_el2 && !x.secure && (c.trap_dbg || c.trap_gen);
        return to_hyp ? LVL_2 : LVL_1;
    endfunction

endpackage

// File: rtl/dbg_ctrl_regs.sv
module dbg_ctrl_regs
    import dbg_arb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output dbg_ctrl_t         ctrl
);

    dbg_ctrl_t ctrl_q;
    wsel_e     sel;

    assign sel  = wsel_e'(wr_sel);
    assign ctrl = ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (sel)
                WSEL_SCOPE: begin
                    ctrl_q.mon_en  <= wr_data[SCOPE_MON_BIT];
                    ctrl_q.kern_en <= wr_data[SCOPE_KERN_BIT];
                    ctrl_q.step_en <= wr_data[SCOPE_STEP_BIT];
                end
                WSEL_EL3CFG: ctrl_q.sec_dis <= wr_data[EL3CFG_SDIS_BIT];
                WSEL_LOCK:   ctrl_q.os_lock <= wr_data[LOCK_BIT];
                WSEL_ROUTE: begin
                    ctrl_q.trap_dbg <= wr_data[ROUTE_TDBG_BIT];
                    ctrl_q.trap_gen <= wr_data[ROUTE_TGEN_BIT];
                end
                default: ctrl_q <= ctrl_q;
            endcase
        end
    end

endmodule

// File: rtl/dbg_route.sv
module dbg_route
    import dbg_arb_pkg::*;
(
    input  dbg_ctrl_t ctrl,
    input  dbg_ctx_t  ctx,
    output lvl_e      target
);

    assign target = route_level(ctrl, ctx);

endmodule

// File: rtl/dbg_enable_eval.sv
module dbg_enable_eval
    import dbg_arb_pkg::*;
(
    input  dbg_ctrl_t ctrl,
    input  dbg_ctx_t  ctx,
    input  lvl_e      target,
    output logic      allowed
);

    logic veto;
    logic at_target;
    logic below_target;

    always_comb begin
        veto         = ctrl.os_lock || (ctrl.sec_dis && ctx.secure && ctx.has_el3);
        at_target    = (ctx.lvl == target);
        below_target = (ctx.lvl < target);
        if (veto)
            allowed = 1'b0;
        else if (at_target)
            allowed = ctrl.kern_en && !ctx.mask;
        else
            allowed = below_target;
    end

endmodule

// File: rtl/dbg_enable_arbiter.sv
module dbg_enable_arbiter
    import dbg_arb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cur_el,
    input  logic              secure,
    input  logic              has_el2,
    input  logic              has_el3,
    input  logic              dbg_mask,
    output logic [1:0]        target_el,
    output logic              dbg_allowed,
    output logic              mon_dbg_en,
    output logic              step_en
);

    localparam int SPARE_W = DATA_W - MIN_DATA_W;

    dbg_ctrl_t ctrl;
    dbg_ctx_t  ctx;
    lvl_e      target;

    generate
        if (SPARE_W < 0) begin : g_bad_width
            initial $error("DATA_W too narrow for control word fields");
        end
    endgenerate

    assign ctx.lvl     = lvl_e'(cur_el);
    assign ctx.secure  = secure;
    assign ctx.has_el2 = has_el2;
    assign ctx.has_el3 = has_el3;
    assign ctx.mask    = dbg_mask;

    dbg_ctrl_regs #(.DATA_W(DATA_W)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    dbg_route i_route (
        .ctrl   (ctrl),
        .ctx    (ctx),
        .target (target)
    );

    dbg_enable_eval i_eval (
        .ctrl    (ctrl),
        .ctx     (ctx),
        .target  (target),
        .allowed (dbg_allowed)
    );

    assign target_el  = target;
    assign mon_dbg_en = ctrl.mon_en;
    assign step_en    = ctrl.step_en;

endmodule

// File: rtl/dbg_enable_arbiter_chk.sv
module dbg_enable_arbiter_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        cur_el,
    input logic              secure,
    input logic              has_el2,
    input logic              has_el3,
    input logic              dbg_mask,
    input logic [1:0]        target_el,
    input logic              dbg_allowed,
    input logic              mon_dbg_en,
    input logic              step_en
);

    // R6: a lock word with bit 0 set forbids debug on the following cycle
    a_r6_lock_blocks: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && wr_data[0]) |=> !dbg_allowed);

    // R7: secure disable written, then secure with EL3 present is refused
    a_r7_secure_disable: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1 && wr_data[16]) |=> !(secure && has_el3 && dbg_allowed));

    // R8: routing never leaves EL1 without an EL2 or in secure state
    a_r8_no_hyp_route: assert property (@(posedge clk) disable iff (rst)
        (!has_el2 || secure) |-> (target_el == 2'd1));

    // R8: target is always 1 or 2
    a_r8_target_legal: assert property (@(posedge clk) disable iff (rst)
        (target_el == 2'd1) || (target_el == 2'd2));

    // R9: masked at the target level means no debug
    a_r9_mask_at_target: assert property (@(posedge clk) disable iff (rst)
        (cur_el == target_el && dbg_mask) |-> !dbg_allowed);

    // R10: levels above the target never take debug
    a_r10_above_target: assert property (@(posedge clk) disable iff (rst)
        (cur_el > target_el) |-> !dbg_allowed);

    // R12: without a strobe the held enables keep their value
    a_r12_no_strobe_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(mon_dbg_en) && $stable(step_en)));

    // R2: scope write loads the step bit from data bit 0
    a_r2_step_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0) |=> (step_en == $past(wr_data[0])));

endmodule

bind dbg_enable_arbiter dbg_enable_arbiter_chk #(.DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .cur_el      (cur_el),
    .secure      (secure),
    .has_el2     (has_el2),
    .has_el3     (has_el3),
    .dbg_mask    (dbg_mask),
    .target_el   (target_el),
    .dbg_allowed (dbg_allowed),
    .mon_dbg_en  (mon_dbg_en),
    .step_en     (step_en)
);

// File: tb/test_dbg_enable_arbiter.sv
module test_dbg_enable_arbiter;

    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = 2'd0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [1:0]        cur_el = 2'd0;
    logic              secure = 1'b0;
    logic              has_el2 = 1'b0;
    logic              has_el3 = 1'b0;
    logic              dbg_mask = 1'b0;
    logic [1:0]        target_el;
    logic              dbg_allowed;
    logic              mon_dbg_en;
    logic              step_en;

    always #2 clk = ~clk;

    dbg_enable_arbiter #(.DATA_W(DATA_W)) i_dbg_enable_arbiter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cur_el(cur_el), .secure(secure), .has_el2(has_el2), .has_el3(has_el3),
        .dbg_mask(dbg_mask), .target_el(target_el), .dbg_allowed(dbg_allowed),
        .mon_dbg_en(mon_dbg_en), .step_en(step_en)
    );

    typedef struct {
        logic [1:0] tgt;
        logic       ok;
        logic       mon;
        logic       stp;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // shadow of the held control bits, kept from the requirements
    logic s_lock = 0, s_sdis = 0, s_kern = 0, s_mon = 0, s_step = 0, s_tdbg = 0, s_tgen = 0;

    task automatic do_write(input logic [1:0] sel, input logic [DATA_W-1:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = '0;
        case (sel)
            2'd0: begin s_mon = d[15]; s_kern = d[13]; s_step = d[0]; end
            2'd1: s_sdis = d[16];
            2'd2: s_lock = d[0];
            default: begin s_tdbg = d[0]; s_tgen = d[1]; end
        endcase
    endtask

    task automatic apply(input logic [1:0] el, input logic sec, input logic e2,
                         input logic e3, input logic m, input string tag);
        exp_t e;
        logic [1:0] t;
        logic v;
        @(posedge clk); #1;
        cur_el = el; secure = sec; has_el2 = e2; has_el3 = e3; dbg_mask = m;
        t = (e2 && !sec && (s_tdbg || s_tgen)) ? 2'd2 : 2'd1;
        if (s_lock || (s_sdis && sec && e3)) v = 1'b0;
        else if (el == t)                    v = s_kern && !m;
        else                                 v = (el < t);
        e.tgt = t; e.ok = v; e.mon = s_mon; e.stp = s_step; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk); #1;
    endtask

    // monitor: compares at the falling edge, away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (target_el !== e.tgt || dbg_allowed !== e.ok ||
                    mon_dbg_en !== e.mon || step_en !== e.stp) begin
                    n_fail++;
                    $display("FAIL %s: got tgt=%0d ok=%0b mon=%0b step=%0b, expected tgt=%0d ok=%0b mon=%0b step=%0b",
                             e.tag, target_el, dbg_allowed, mon_dbg_en, step_en,
                             e.tgt, e.ok, e.mon, e.stp);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        apply(2'd0, 0, 0, 0, 0, "R1 reset el0");
        apply(2'd1, 0, 0, 0, 0, "R1 reset el1");

        // R2: scope word, bits 15 and 13, bit 0 clear
        do_write(2'd0, 32'h0000_A000);
        apply(2'd1, 0, 0, 0, 0, "R2 R9 kern set unmasked");
        apply(2'd1, 0, 0, 0, 1, "R9 kern set masked");
        // R2: other bits ignored, step from bit 0
        do_write(2'd0, 32'hFFFF_5FFF);
        apply(2'd1, 0, 0, 0, 0, "R2 step only kern clear");

        // R12: data without strobe changes nothing
        @(posedge clk); #1;
        wr_sel = 2'd0; wr_data = 32'h0000_A000;
        @(posedge clk); #1;
        wr_sel = 2'd2; wr_data = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        wr_data = '0;
        apply(2'd0, 0, 0, 0, 0, "R12 no strobe el0");
        apply(2'd1, 0, 0, 0, 0, "R12 no strobe el1");

        do_write(2'd0, 32'h0000_2000);
        // R10 / R11: sweep levels with EL1 target
        apply(2'd0, 0, 1, 1, 1, "R10 below target");
        apply(2'd2, 0, 1, 1, 0, "R10 above target el2");
        apply(2'd3, 0, 1, 1, 0, "R10 above target el3");

        // R5 R8: trap-debug bit routes to EL2
        do_write(2'd3, 32'h0000_0001);
        apply(2'd1, 0, 1, 1, 1, "R8 R10 el1 below el2 target");
        apply(2'd2, 0, 1, 1, 0, "R8 R9 at el2 target");
        apply(2'd2, 0, 1, 1, 1, "R9 at el2 target masked");
        apply(2'd3, 0, 1, 1, 0, "R10 above el2 target");
        apply(2'd1, 1, 1, 1, 0, "R8 secure keeps el1");
        apply(2'd2, 0, 0, 1, 0, "R8 R11 no el2 keeps el1");
        do_write(2'd3, 32'h0000_0002);
        apply(2'd2, 0, 1, 0, 0, "R5 trap-general routes");
        do_write(2'd3, 32'hFFFF_FFFC);
        apply(2'd2, 0, 1, 0, 0, "R5 routing cleared");

        // R3 R7: secure debug disable
        do_write(2'd1, 32'h0001_0000);
        apply(2'd0, 1, 1, 1, 0, "R3 R7 secure with el3");
        apply(2'd0, 1, 1, 0, 0, "R7 secure no el3");
        apply(2'd0, 0, 1, 1, 0, "R7 nonsecure");
        do_write(2'd1, 32'hFFFE_FFFF);
        apply(2'd0, 1, 1, 1, 0, "R3 disable cleared");

        // R4 R6: OS lock
        do_write(2'd2, 32'h0000_0001);
        apply(2'd0, 0, 0, 0, 0, "R4 R6 lock el0");
        apply(2'd1, 0, 0, 0, 0, "R6 lock at target");
        do_write(2'd2, 32'hFFFF_FFFE);
        apply(2'd0, 0, 0, 0, 0, "R4 lock released");

        // R1: reset clears everything again
        do_write(2'd0, 32'h0000_A001);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        s_lock = 0; s_sdis = 0; s_kern = 0; s_mon = 0; s_step = 0; s_tdbg = 0; s_tgen = 0;
        apply(2'd1, 0, 0, 0, 0, "R1 reset again");

        repeat (2) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule